// File: doc/BRIEF.md
# SMIC Host Transaction Sequencer

This block runs one request/response exchange with a management controller from the host side, through a window of three byte registers: data at offset 0, control/status at offset 1 and flags at offset 2. The requester first loads the request bytes into the block's buffer and then pulses `start` with the length. The sequencer then works through a fixed handshake. Each command is a control-code write followed by a write of the flags register with the busy bit set. Every following step waits for the busy bit to clear and checks the returned status code.

Response bytes are collected into an internal buffer, which the requester reads through a combinational port once `done` pulses. A wrong status code, a nonzero end-of-phase error byte or a stalled handshake restarts the whole exchange from the beginning. Once the retry budget is spent, `failed` pulses and the block returns to idle. While idle, the block keeps polling the flags register. It raises an attention output when the controller has a message waiting, and it reports an absent device when the flags register reads all ones.

Top module: `smic_seq`

## Requirements
- R1: A start with a length below 2 or above DEPTH (80), or a start while `busy` is high, pulses `start_rej` one cycle later and does not begin an exchange. An accepted start leaves `start_rej` low.
- R2: Every command is a write of a control code to offset 1, followed in the very next cycle by a write to offset 2 with bit 0 (busy) set.
- R3: After a flags read at offset 2 returns bit 0 set during an exchange, the block issues no register write in the following cycle. It only re-reads the flags.
- R4: An exchange opens with control code 0x40. It must then see status 0xC0, and it then issues 0x41 together with request byte 0.
- R5: Request bytes after the first are written only once flags bit 6 (transmit ready) has been read as set. The last byte goes with 0x43 and each earlier byte goes with 0x42.
- R6: After status 0xC3, the data register is read as an error code, and a nonzero code restarts the exchange. After that, 0x44 is issued only once flags bit 7 (receive ready) has been read as set.
- R7: In the read phase, each byte is taken after status 0xC4 or 0xC5 with bit 7 set, and is followed by 0x45. Status 0xC6 marks the last byte, which is taken and followed by 0x46. A final status 0xC0 with data 0 pulses `done`.
- R8: Any unexpected status restarts the exchange from code 0x40. When the number of restarts would exceed MAX_RETRY (3), `failed` pulses instead, so an exchange makes at most 4 attempts.
- R9: If TO_CYCLES cycles pass during an exchange without a completed step, the exchange restarts, counting toward the limit in R8.
- R10: Response bytes beyond DEPTH are read from the data register and dropped. `rsp_len` then reads DEPTH and byte 2 reads 0xC6.
- R11: A response of fewer than 3 bytes gives `rsp_len` = 3 with byte 2 reading 0xFF. Otherwise `rsp_len` is the byte count and every byte reads as received.
- R12: While idle, `attn` follows flags bit 2 when bit 0 is clear, and flags bits 4 and 3 have no effect on it. `no_dev` is set while the flags read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_we | input | 1 | Request buffer write strobe |
| req_addr | input | 7 | Request buffer write index |
| req_data | input | 8 | Request buffer write byte |
| start | input | 1 | Begin an exchange |
| req_len | input | 7 | Request length in bytes |
| start_rej | output | 1 | Start refused (pulse) |
| reg_rd | output | 1 | Register window read |
| reg_wr | output | 1 | Register window write |
| reg_addr | output | 2 | Register offset |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte, same cycle |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange completed (pulse) |
| failed | output | 1 | Retries exhausted (pulse) |
| attn | output | 1 | Controller has a message waiting |
| no_dev | output | 1 | Flags read all ones |
| rsp_addr | input | 7 | Response read index |
| rsp_data | output | 8 | Response byte at rsp_addr |
| rsp_len | output | 7 | Response length |

## Verification
The assertions assume the register window returns read data in the same cycle it is addressed. They also assume a stable request buffer and `start` pulses lasting one cycle. The bench's controller model drives the window combinationally from its registers and changes them only on clock edges. It clears busy after 0 to 3 cycles and raises transmit or receive ready after a random lag. It reacts only to commands that set the busy bit, so the handshake the assertions rely on is always present. Faults are injected at chosen points: a wrong status, a nonzero write-end code, and a busy bit that never clears.

// File: rtl/smic_seq.sv
module smic_seq #(
  parameter int DEPTH     = 80,
  parameter int MAX_RETRY = 3,
  parameter int TO_CYCLES = 100_000_000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_we,
  input  logic [$clog2(DEPTH)-1:0]     req_addr,
  input  logic [7:0]                   req_data,
  input  logic                         start,
  input  logic [$clog2(DEPTH+1)-1:0]   req_len,
  output logic                         start_rej,
  output logic                         reg_rd,
  output logic                         reg_wr,
  output logic [1:0]                   reg_addr,
  output logic [7:0]                   reg_wdata,
  input  logic [7:0]                   reg_rdata,
  output logic                         busy,
  output logic                         done,
  output logic                         failed,
  output logic                         attn,
  output logic                         no_dev,
  input  logic [$clog2(DEPTH)-1:0]     rsp_addr,
  output logic [7:0]                   rsp_data,
  output logic [$clog2(DEPTH+1)-1:0]   rsp_len
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TO_CYCLES+1);
  localparam int RW = $clog2(MAX_RETRY+2);

  typedef enum logic [3:0] {P_IDLE, P_OPEN, P_CHK, P_WS, P_WN, P_WE, P_W2R,
                            P_RS, P_RN, P_RE, P_FAIL} phase_t;
  typedef enum logic [2:0] {S_FLG, S_STS, S_DAT, S_CTL, S_FWR} step_t;
  typedef enum logic [1:0] {D_NONE, D_WR, D_TAKE, D_CHK} dact_t;

  phase_t phase, nxt, nx;
  step_t  step;
  dact_t  dact, dd;
  logic [7:0]    ctl_q, flg_q, cc;
  logic [7:0]    wbuf [DEPTH];
  logic [7:0]    rbuf [DEPTH];
  logic [LW-1:0] len_q, wpos, rpos;
  logic [RW-1:0] retry;
  logic [TW-1:0] to_cnt;
  logic          trunc, go, err, acc, rec, take_en, last;
  logic [RW-1:0] rnext;

  assign busy  = (phase != P_IDLE) && (phase != P_FAIL);
  assign acc   = start && !busy && req_len >= LW'(2) && req_len <= LW'(DEPTH);
  assign last  = (len_q - wpos) == LW'(1);
  assign rnext = retry + RW'(1);

  always_comb begin
    go = 1'b0; err = 1'b0; dd = D_NONE; cc = 8'h40; nx = phase;
    case (phase)
      P_OPEN: begin go = 1'b1; nx = P_CHK; end
      P_CHK:
        if (reg_rdata != 8'hC0) err = 1'b1;
        else begin go = 1'b1; dd = D_WR; cc = 8'h41; nx = P_WS; end
      P_WS, P_WN:
        if (reg_rdata != ((phase == P_WS) ? 8'hC1 : 8'hC2)) err = 1'b1;
        else if (flg_q[6]) begin
          go = 1'b1; dd = D_WR;
          cc = last ? 8'h43 : 8'h42;
          nx = last ? P_WE : P_WN;
        end
      P_WE:
        if (reg_rdata != 8'hC3) err = 1'b1;
        else begin go = 1'b1; dd = D_CHK; nx = P_W2R; end
      P_W2R:
        if (flg_q[7]) begin go = 1'b1; cc = 8'h44; nx = P_RS; end
      P_RS:
        if (reg_rdata != 8'hC4) err = 1'b1;
        else if (flg_q[7]) begin go = 1'b1; dd = D_TAKE; cc = 8'h45; nx = P_RN; end
      P_RN:
        if (reg_rdata == 8'hC6) begin go = 1'b1; dd = D_TAKE; cc = 8'h46; nx = P_RE; end
        else if (reg_rdata == 8'hC5) begin
          if (flg_q[7]) begin go = 1'b1; dd = D_TAKE; cc = 8'h45; nx = P_RN; end
        end else err = 1'b1;
      P_RE:
        if (reg_rdata != 8'hC0) err = 1'b1;
        else begin go = 1'b1; dd = D_CHK; nx = P_IDLE; end
      default: ;
    endcase
  end

  assign rec = busy && ((to_cnt == '0) || (step == S_STS && err) ||
                        (step == S_DAT && dact == D_CHK && reg_rdata != 8'h00));
  assign take_en = !rec && step == S_DAT && dact == D_TAKE && rpos < LW'(DEPTH);

  always_ff @(posedge clk) begin
    if (req_we) wbuf[req_addr] <= req_data;
    if (take_en) rbuf[rpos[AW-1:0]] <= reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_cnt <= TW'(TO_CYCLES);
    else if (acc || rec || step == S_FWR || (step == S_DAT && dact == D_CHK))
      to_cnt <= TW'(TO_CYCLES);
    else if (busy && to_cnt != '0) to_cnt <= to_cnt - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; nxt <= P_IDLE; step <= S_FLG; dact <= D_NONE;
      ctl_q <= '0; flg_q <= '0; len_q <= '0; wpos <= '0; rpos <= '0;
      retry <= '0; trunc <= 1'b0; start_rej <= 1'b0; done <= 1'b0;
      failed <= 1'b0; attn <= 1'b0; no_dev <= 1'b0;
    end else begin
      start_rej <= start && !acc;
      done      <= 1'b0;
      failed    <= 1'b0;
      if (acc) begin
        len_q <= req_len; wpos <= '0; rpos <= '0; trunc <= 1'b0;
        retry <= '0; phase <= P_OPEN; step <= S_FLG; attn <= 1'b0;
      end else if (rec) begin
        retry <= rnext; step <= S_FLG;
        wpos <= '0; rpos <= '0; trunc <= 1'b0;
        phase <= (rnext > RW'(MAX_RETRY)) ? P_FAIL : P_OPEN;
      end else begin
        case (step)
          S_FLG:
            if (phase == P_FAIL) begin
              phase <= P_IDLE; failed <= 1'b1;
            end else begin
              flg_q <= reg_rdata;
              if (phase == P_IDLE) begin
                attn   <= !reg_rdata[0] && reg_rdata[2];
                no_dev <= reg_rdata == 8'hFF;
              end else if (!reg_rdata[0]) step <= S_STS;
            end
          S_STS:
            if (go) begin
              ctl_q <= cc; dact <= dd; nxt <= nx;
              step  <= (dd != D_NONE) ? S_DAT : S_CTL;
            end else step <= S_FLG;
          S_DAT:
            case (dact)
              D_WR:   begin wpos <= wpos + LW'(1); step <= S_CTL; end
              D_TAKE: begin
                if (rpos < LW'(DEPTH)) rpos <= rpos + LW'(1);
                else trunc <= 1'b1;
                step <= S_CTL;
              end
              default: begin
                phase <= nxt; step <= S_FLG;
                done  <= nxt == P_IDLE;
              end
            endcase
          S_CTL: step <= S_FWR;
          default: begin phase <= nxt; step <= S_FLG; end
        endcase
      end
    end
  end

  assign reg_rd = (step == S_FLG && phase != P_FAIL) || step == S_STS ||
                  (step == S_DAT && dact != D_WR);
  assign reg_wr = (step == S_DAT && dact == D_WR) || step == S_CTL || step == S_FWR;
  assign reg_addr = (step == S_DAT) ? 2'd0 :
                    (step == S_STS || step == S_CTL) ? 2'd1 : 2'd2;
  assign reg_wdata = (step == S_DAT) ? wbuf[wpos[AW-1:0]] :
                     (step == S_CTL) ? ctl_q : (flg_q | 8'h01);

  assign rsp_len  = trunc ? LW'(DEPTH) : (rpos < LW'(3)) ? LW'(3) : rpos;
  assign rsp_data = (rsp_addr == AW'(2) && trunc) ? 8'hC6 :
                    (rsp_addr == AW'(2) && rpos < LW'(3)) ? 8'hFF : rbuf[rsp_addr];

  // R2
  ctl_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (reg_wr && reg_addr == 2'd2 && reg_wdata[0]));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_rd && reg_addr == 2'd2 && reg_rdata[0]) |=> !reg_wr);
  // R5
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && wpos != '0) |-> flg_q[6]);
  // R8
  fail_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> retry == RW'(MAX_RETRY + 1));
  // R12
  attn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attn |-> phase == P_IDLE);
endmodule

// File: tb/smic_seq_tb_top.sv
module smic_seq_tb_top;
  localparam int DEPTH = 80;
  localparam int TO    = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_we = 0, start = 0;
  logic [6:0] req_addr = 0, req_len = 0, rsp_addr = 0;
  logic [7:0] req_data = 0;
  logic start_rej, reg_rd, reg_wr, busy, done, failed, attn, no_dev;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, rsp_data;
  logic [6:0] rsp_len;

  smic_seq #(.DEPTH(DEPTH), .MAX_RETRY(3), .TO_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_addr(req_addr),
    .req_data(req_data), .start(start), .req_len(req_len),
    .start_rej(start_rej), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .failed(failed), .attn(attn), .no_dev(no_dev),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_len(rsp_len));

  // controller model; bench-owned knobs
  logic sms = 0, j4 = 0, j3 = 0, nodev = 0, stuck = 0;
  logic [7:0] req [128];
  logic [7:0] rsp [128];
  int r_len = 2, werr_at = -1, bad_until = 0;
  // model-owned state
  logic m_busy, m_tx, m_rx, lag_on, lag_rx;
  logic [7:0] m_status, m_data, m_ctl, m_hdata;
  logic [7:0] cap [128];
  int cap_n, r_idx, bcnt, lag, n40, n42, n43, n43p, n40p, wr_cnt;

  assign reg_rdata = (reg_addr == 2'd0) ? m_data : (reg_addr == 2'd1) ? m_status :
                     nodev ? 8'hFF : {m_rx, m_tx, 1'b0, j4, j3, sms, 1'b0, m_busy};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_tx <= 0; m_rx <= 0; lag_on <= 0; lag_rx <= 0; lag <= 0;
      m_status <= 8'hC0; m_data <= 0; m_ctl <= 0; m_hdata <= 0;
      cap_n <= 0; r_idx <= 0; bcnt <= 0; n40 <= 0; n42 <= 0; n43 <= 0;
      n43p <= 0; n40p <= 0; wr_cnt <= 0;
    end else begin
      if (reg_wr) begin
        wr_cnt <= wr_cnt + 1;
        case (reg_addr)
          2'd0: m_hdata <= reg_wdata;
          2'd1: begin
            m_ctl <= reg_wdata;
            if (reg_wdata == 8'h40) n40 <= n40 + 1;
            if (reg_wdata == 8'h42) n42 <= n42 + 1;
            if (reg_wdata == 8'h43) n43 <= n43 + 1;
          end
          default: if (reg_wdata[0]) begin
            m_busy <= 1; bcnt <= int'($urandom % 4); m_tx <= 0; m_rx <= 0; lag_on <= 0;
          end
        endcase
      end else if (m_busy) begin
        if (bcnt != 0) bcnt <= bcnt - 1;
        else if (!stuck) begin
          m_busy <= 0;
          case (m_ctl)
            8'h40: begin
              m_status <= (n40p < bad_until) ? 8'hC7 : 8'hC0;
              n40p <= n40p + 1; cap_n <= 0;
            end
            8'h41, 8'h42: begin
              m_status <= (m_ctl == 8'h41) ? 8'hC1 : 8'hC2;
              cap[(m_ctl == 8'h41) ? 0 : cap_n] <= m_hdata;
              cap_n <= (m_ctl == 8'h41) ? 1 : cap_n + 1;
              lag_on <= 1; lag_rx <= 0; lag <= int'($urandom % 5);
            end
            8'h43: begin
              m_status <= 8'hC3; cap[cap_n] <= m_hdata; cap_n <= cap_n + 1;
              m_data <= (n43p == werr_at) ? 8'h05 : 8'h00; n43p <= n43p + 1;
              lag_on <= 1; lag_rx <= 1; lag <= int'($urandom % 5);
            end
            8'h44: begin m_status <= 8'hC4; m_data <= rsp[0]; r_idx <= 1; m_rx <= 1; end
            8'h45: begin
              m_status <= (r_idx == r_len - 1) ? 8'hC6 : 8'hC5;
              m_data <= rsp[r_idx]; r_idx <= r_idx + 1; m_rx <= 1;
            end
            8'h46: begin m_status <= 8'hC0; m_data <= 8'h00; end
            default: m_status <= 8'hC7;
          endcase
        end
      end else if (lag_on) begin
        if (lag != 0) lag <= lag - 1;
        else begin lag_on <= 0; if (lag_rx) m_rx <= 1; else m_tx <= 1; end
      end
    end
  end

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (cyc > 190000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog: act=%0d exp<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: act=%0h exp=%0h", r, act, exp); end
  endtask

  function automatic int exp_len(input int n);
    return (n > DEPTH) ? DEPTH : (n < 3) ? 3 : n;
  endfunction
  function automatic int exp_byte(input int i, input int n);
    if (i == 2 && n > DEPTH) return 8'hC6;
    if (i == 2 && n < 3) return 8'hFF;
    return int'(rsp[i]);
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic launch(input int len);
    for (int i = 0; i < len; i++) begin
      req[i] = 8'($urandom); req_we = 1; req_addr = 7'(i); req_data = req[i];
      @(negedge clk);
    end
    req_we = 0; req_len = 7'(len); start = 1;
    @(negedge clk);
    start = 0;
    chk(start_rej == 0, "R1 accepted start", start_rej, 0);
  endtask

  task automatic wait_end(output int res, output int elapsed);
    res = 0; elapsed = 0;
    while (res == 0 && elapsed < 30000) begin
      @(negedge clk); elapsed++;
      if (done) res = 1; else if (failed) res = 2;
    end
  endtask

  task automatic xfer(input int len, input int rl, input string r);
    int res, el, b40, b42, b43;
    r_len = rl;
    for (int i = 0; i < rl; i++) rsp[i] = 8'($urandom);
    b40 = n40; b42 = n42; b43 = n43;
    launch(len);
    wait_end(res, el);
    chk(res == 1, {r, " done"}, res, 1);
    chk(cap_n == len, "R4 request count", cap_n, len);
    for (int i = 0; i < len; i++)
      if (cap[i] != req[i]) chk(0, "R4 R5 request byte", cap[i], req[i]);
    if (werr_at < 0 && bad_until <= n40p)
      chk(n40 - b40 == 1 && n43 - b43 == 1 && n42 - b42 == len - 2,
          "R5 tag counts", n42 - b42, len - 2);
    chk(rsp_len == 7'(exp_len(rl)), {r, " rsp_len"}, rsp_len, exp_len(rl));
    for (int i = 0; i < exp_len(rl); i++) begin
      rsp_addr = 7'(i); #1;
      if (i >= 2 && rsp_data != 8'(exp_byte(i, rl)))
        chk(0, {r, " R7 rsp byte"}, rsp_data, exp_byte(i, rl));
      if (i < 2 && rsp_data != rsp[i]) chk(0, {r, " R7 rsp byte"}, rsp_data, rsp[i]);
    end
    ticks(3);
  endtask

  initial begin
    int res, el, b40, bw;
    void'($urandom(32'd2024));
    ticks(3);
    rst_n = 1;
    ticks(2);
    chk(!done && !failed && !attn && !busy && !reg_wr, "reset state", {done, failed, attn, busy}, 0);
    // R1 bad lengths
    req_len = 7'd1; start = 1; @(negedge clk); start = 0;
    chk(start_rej && !busy, "R1 len 1", start_rej, 1);
    req_len = 7'd81; start = 1; @(negedge clk); start = 0;
    chk(start_rej && !busy, "R1 len 81", start_rej, 1);
    // directed minimum request and short response
    xfer(2, 2, "R11 short");
    // random exchanges
    for (int k = 0; k < 10; k++) xfer(2 + int'($urandom % 79), 3 + int'($urandom % 78), "R7 random");
    xfer(80, 80, "R7 full");
    // truncation
    xfer(5, 85, "R10 trunc");
    // start while busy
    r_len = 4; launch(6); ticks(2);
    req_len = 7'd6; start = 1; @(negedge clk); start = 0;
    chk(start_rej == 1, "R1 start while busy", start_rej, 1);
    wait_end(res, el);
    chk(res == 1, "R1 first exchange still completes", res, 1);
    ticks(3);
    // write-end error code -> retry
    werr_at = n43p; b40 = n40;
    xfer(7, 9, "R6 werr");
    chk(n40 - b40 == 2, "R6 restart count", n40 - b40, 2);
    werr_at = -1;
    // persistent bad status -> failed after 4 attempts
    bad_until = n40p + 10; b40 = n40;
    r_len = 4; launch(4); wait_end(res, el);
    chk(res == 2, "R8 failed", res, 2);
    chk(n40 - b40 == 4, "R8 attempts", n40 - b40, 4);
    bad_until = 0; ticks(3);
    chk(!busy, "R8 back to idle", busy, 0);
    // single stall -> timeout -> recovery
    stuck = 1; b40 = n40; r_len = 5; launch(3);
    ticks(TO + 50); stuck = 0;
    wait_end(res, el);
    chk(res == 1, "R9 recovers after timeout", res, 1);
    chk(n40 - b40 == 2, "R9 restart count", n40 - b40, 2);
    ticks(3);
    // permanent stall -> no writes while busy, then failed
    stuck = 1; launch(3); bw = wr_cnt; wait_end(res, el);
    chk(res == 2, "R9 permanent stall fails", res, 2);
    chk(el >= 3 * TO, "R9 timeout length", el, 3 * TO);
    chk(wr_cnt - bw <= 2, "R3 writes during busy", wr_cnt - bw, 2);
    stuck = 0; ticks(10);
    // attention and presence
    sms = 1; ticks(3);
    chk(attn == 1, "R12 attn set", attn, 1);
    sms = 0; j4 = 1; j3 = 1; ticks(3);
    chk(attn == 0, "R12 ignored bits", attn, 0);
    j4 = 0; j3 = 0; nodev = 1; ticks(3);
    chk(no_dev == 1 && attn == 0, "R12 no device", no_dev, 1);
    nodev = 0; ticks(3);
    chk(no_dev == 0, "R12 device back", no_dev, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule